// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the execution stage for a small accumulator machine. It holds two byte-wide accumulators, A and B. The two together also act as one double-width register D, with A as the upper half. It also holds five condition flags: half-carry H, negative N, zero Z, overflow V and carry C. The instruction fetcher decodes the addressing mode and fetches the operand. It then presents an opcode and that operand together with a one-cycle start pulse. The block runs the add, AND, bit-test and arithmetic shift operations against the accumulators.

Each opcode has a fixed cycle count. The block holds busy for that count minus one cycle and then writes the accumulators and flags together on the cycle that busy falls. Each instruction changes only its own subset of the flags and leaves the rest as they were. The byte width is a parameter. The opcode encoding is fixed at eight bits, and the cycle counts are parameters.

Top module: `acc_alu_core`

## Requirements
- R1: After a synchronous active-low reset, A, B, all flags and busy are 0.
- R2: A start pulse with a known opcode while idle raises busy on the next cycle. Busy stays high for the cycle count minus one cycle: 4 cycles for the double add, 3 for the double shift and 2 for every other opcode. A, B and the flags hold their values while busy and take their new values in the cycle busy falls.
- R3: A start pulse while busy, or a start pulse with an opcode outside the set below, is ignored: busy does not rise and A, B and the flags do not change.
- R4: Opcode 0xCB adds the low byte of the operand to B, writes the sum to B and updates H, N, Z, V and C.
- R5: Opcode 0xC3 adds the whole double-width operand to D, writes the sum back to A:B, updates N, Z, V and C, and keeps H.
- R6: Opcodes 0x84 and 0xC4 write A AND operand-low-byte into A and into B respectively. They update N and Z, clear V, and keep C and H.
- R7: Opcode 0x85 forms A AND operand-low-byte and sets the flags the same way as R6. It leaves A and B unchanged.
- R8: Opcodes 0x48 (A) and 0x58 (B) shift the accumulator left by one place. A 0 enters the lowest bit and the old top bit goes to C.
- R9: Opcode 0x05 shifts A:B left as one word. The top bit of B enters the lowest bit of A, the old top bit of A goes to C, and a 0 enters the lowest bit of B.
- R10: Opcodes 0x47 (A) and 0x57 (B) shift the accumulator right by one place. The top bit keeps its value and the old lowest bit goes to C.
- R11: Every shift sets N and Z from its result, sets V to N XOR C as they stand after the shift, and keeps H.
- R12: The flag output is ordered ccr_o[4]=H, [3]=N, [2]=Z, [1]=V, [0]=C. N is the top bit of the result, and Z means the full result is zero; both are taken over 16 bits for opcodes 0xC3 and 0x05. V marks signed overflow on the adds. H is the carry out of the low half-byte (bit 3 into bit 4 at byte width 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that accepts opcode_i and operand_i |
| opcode_i | input | 8 | Operation code |
| operand_i | input | 2*DATA_W | Fetched operand; byte operations use the low byte |
| busy_o | output | 1 | High while an accepted operation is in progress |
| acc_a_o | output | DATA_W | Accumulator A |
| acc_b_o | output | DATA_W | Accumulator B |
| ccr_o | output | 5 | Flags {H,N,Z,V,C} |

## Verification
The bench builds the block with its default byte width of 8 and cycle counts of 2, 3 and 4. At this size a bench model written with integer arithmetic can predict every result and flag. The bench sets D to each pair drawn from a grid of byte values, which includes 0x00, 0x01, 0x7F, 0x80 and 0xFF. It then runs every opcode from that state, so that carry, half-carry, signed overflow, zero results and sign bits are all reached through the accumulators. The same runs measure the busy length of every opcode. Separate cases issue a start while busy and an unknown opcode, and check that both are ignored.

// File: rtl/acc_pkg.sv
// Shared definitions for the accumulator ALU: opcode values, the internal
// operation code and the flag record. Assumes eight-bit opcodes.
package acc_pkg;

    localparam logic [7:0] OPC_ADD_B  = 8'hCB;
    localparam logic [7:0] OPC_ADD_D  = 8'hC3;
    localparam logic [7:0] OPC_AND_A  = 8'h84;
    localparam logic [7:0] OPC_AND_B  = 8'hC4;
    localparam logic [7:0] OPC_TST_A  = 8'h85;
    localparam logic [7:0] OPC_SHL_A  = 8'h48;
    localparam logic [7:0] OPC_SHL_B  = 8'h58;
    localparam logic [7:0] OPC_SHL_D  = 8'h05;
    localparam logic [7:0] OPC_SHR_A  = 8'h47;
    localparam logic [7:0] OPC_SHR_B  = 8'h57;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADDB,
        OP_ADDD,
        OP_ANDA,
        OP_ANDB,
        OP_BITA,
        OP_ASLA,
        OP_ASLB,
        OP_ASLD,
        OP_ASRA,
        OP_ASRB
    } alu_op_e;

    // Flag record, ordered as it appears on the flag port (R12).
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/acc_decode.sv
// Opcode decoder: maps the eight-bit opcode to an internal operation, a
// legal flag and the total cycle count. Pure combinational logic.
// Assumes every cycle count is at least 2 and fits in CNT_W bits.
module acc_decode
    import acc_pkg::*;
#(
    parameter int CNT_W     = 3,
    parameter int CYC_SHORT = 2,
    parameter int CYC_ASLD  = 3,
    parameter int CYC_ADDD  = 4
) (
    input  logic [7:0]       opcode_i,
    output alu_op_e          op_o,
    output logic             legal_o,
    output logic [CNT_W-1:0] cyc_o
);

    // Table lookup from opcode to operation and cycle count.
    always_comb begin
        op_o    = OP_NONE;
        legal_o = 1'b1;
        cyc_o   = CNT_W'(CYC_SHORT);
        case (opcode_i)
            OPC_ADD_B: op_o = OP_ADDB;
            OPC_ADD_D: begin op_o = OP_ADDD; cyc_o = CNT_W'(CYC_ADDD); end
            OPC_AND_A: op_o = OP_ANDA;
            OPC_AND_B: op_o = OP_ANDB;
            OPC_TST_A: op_o = OP_BITA;
            OPC_SHL_A: op_o = OP_ASLA;
            OPC_SHL_B: op_o = OP_ASLB;
            OPC_SHL_D: begin op_o = OP_ASLD; cyc_o = CNT_W'(CYC_ASLD); end
            OPC_SHR_A: op_o = OP_ASRA;
            OPC_SHR_B: op_o = OP_ASRB;
            default:   legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_exec.sv
// Combinational execute stage: from the current accumulators, flags and the
// latched operand it forms the next accumulators and flags for one
// operation. Assumes W is even, so that the half-carry point is W/2.
module acc_exec
    import acc_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  ccr_t           ccr_i,
    input  logic [2*W-1:0] opnd_i,
    output logic [W-1:0]   a_o,
    output logic [W-1:0]   b_o,
    output ccr_t           ccr_o
);

    localparam int HW = W / 2;
    localparam int DW = 2 * W;

    logic [W-1:0]  m8;
    logic [W-1:0]  src8;
    logic [W-1:0]  res8;
    logic [W:0]    sum8;
    logic [HW:0]   sumh;
    logic [DW-1:0] d_w;
    logic [DW:0]   sum16;
    logic [DW-1:0] shl16;

    assign m8    = opnd_i[W-1:0];
    assign d_w   = {a_i, b_i};
    assign sum8  = {1'b0, src8} + {1'b0, m8};
    assign sumh  = {1'b0, src8[HW-1:0]} + {1'b0, m8[HW-1:0]};
    assign sum16 = {1'b0, d_w} + {1'b0, opnd_i};
    assign shl16 = {d_w[DW-2:0], 1'b0};

    // Select which accumulator a byte operation reads.
    always_comb begin
        case (op_i)
            OP_ADDB, OP_ANDB, OP_ASLB, OP_ASRB: src8 = b_i;
            default:                            src8 = a_i;
        endcase
    end

    // Per-operation result and flag rules.
    always_comb begin
        a_o   = a_i;
        b_o   = b_i;
        ccr_o = ccr_i;
        res8  = '0;
        case (op_i)
            OP_ADDB: begin
                res8    = sum8[W-1:0];
                b_o     = res8;
                ccr_o.h = sumh[HW];
                ccr_o.c = sum8[W];
                ccr_o.v = (src8[W-1] == m8[W-1]) && (res8[W-1] != src8[W-1]);
                ccr_o.n = res8[W-1];
                ccr_o.z = (res8 == '0);
            end
            OP_ADDD: begin
                {a_o, b_o} = sum16[DW-1:0];
                ccr_o.c    = sum16[DW];
                ccr_o.v    = (d_w[DW-1] == opnd_i[DW-1]) && (sum16[DW-1] != d_w[DW-1]);
                ccr_o.n    = sum16[DW-1];
                ccr_o.z    = (sum16[DW-1:0] == '0);
            end
            OP_ANDA, OP_ANDB, OP_BITA: begin
                res8 = src8 & m8;
                if (op_i == OP_ANDA) a_o = res8;
                if (op_i == OP_ANDB) b_o = res8;
                ccr_o.n = res8[W-1];
                ccr_o.z = (res8 == '0);
                ccr_o.v = 1'b0;
            end
            OP_ASLA, OP_ASLB: begin
                res8 = {src8[W-2:0], 1'b0};
                if (op_i == OP_ASLA) a_o = res8; else b_o = res8;
                ccr_o.c = src8[W-1];
                ccr_o.n = res8[W-1];
                ccr_o.z = (res8 == '0);
                ccr_o.v = res8[W-1] ^ src8[W-1];
            end
            OP_ASRA, OP_ASRB: begin
                res8 = {src8[W-1], src8[W-1:1]};
                if (op_i == OP_ASRA) a_o = res8; else b_o = res8;
                ccr_o.c = src8[0];
                ccr_o.n = res8[W-1];
                ccr_o.z = (res8 == '0);
                ccr_o.v = res8[W-1] ^ src8[0];
            end
            OP_ASLD: begin
                {a_o, b_o} = shl16;
                ccr_o.c    = d_w[DW-1];
                ccr_o.n    = shl16[DW-1];
                ccr_o.z    = (shl16 == '0);
                ccr_o.v    = shl16[DW-1] ^ d_w[DW-1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_core.sv
// Accumulator ALU top: accepts an opcode and operand on a start pulse while
// idle, counts out the instruction's cycles with busy high, and commits the
// accumulators and flags on the final cycle. Assumes the fetcher holds no
// expectation of acceptance while busy; such starts are dropped.
module acc_alu_core
    import acc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CYC_SHORT = 2,
    parameter int CYC_ASLD  = 3,
    parameter int CYC_ADDD  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [7:0]          opcode_i,
    input  logic [2*DATA_W-1:0] operand_i,
    output logic                busy_o,
    output logic [DATA_W-1:0]   acc_a_o,
    output logic [DATA_W-1:0]   acc_b_o,
    output logic [4:0]          ccr_o
);

    localparam int CYC_MAX0 = (CYC_ASLD > CYC_SHORT) ? CYC_ASLD : CYC_SHORT;
    localparam int CYC_MAX  = (CYC_ADDD > CYC_MAX0) ? CYC_ADDD : CYC_MAX0;
    localparam int CNT_W    = $clog2(CYC_MAX + 1);

    alu_op_e             dec_op;
    logic                dec_legal;
    logic [CNT_W-1:0]    dec_cyc;

    alu_op_e             op_q;
    logic [2*DATA_W-1:0] opnd_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                busy_q;
    logic [DATA_W-1:0]   a_q, b_q, a_nx, b_nx;
    ccr_t                ccr_q, ccr_nx;
    logic                accept, commit;

    acc_decode #(
        .CNT_W(CNT_W), .CYC_SHORT(CYC_SHORT), .CYC_ASLD(CYC_ASLD), .CYC_ADDD(CYC_ADDD)
    ) u_decode (
        .opcode_i(opcode_i), .op_o(dec_op), .legal_o(dec_legal), .cyc_o(dec_cyc)
    );

    acc_exec #(.W(DATA_W)) u_exec (
        .op_i(op_q), .a_i(a_q), .b_i(b_q), .ccr_i(ccr_q), .opnd_i(opnd_q),
        .a_o(a_nx), .b_o(b_nx), .ccr_o(ccr_nx)
    );

    assign accept = start_i && !busy_q && dec_legal;
    assign commit = busy_q && (cnt_q == CNT_W'(1));

    // Operation latch, cycle counter and architectural register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            opnd_q <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            ccr_q  <= '0;
        end else if (accept) begin
            op_q   <= dec_op;
            opnd_q <= operand_i;
            cnt_q  <= dec_cyc - CNT_W'(1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (commit) begin
                busy_q <= 1'b0;
                a_q    <= a_nx;
                b_q    <= b_nx;
                ccr_q  <= ccr_nx;
            end
        end
    end

    assign busy_o  = busy_q;
    assign acc_a_o = a_q;
    assign acc_b_o = b_q;
    assign ccr_o   = ccr_q;

    // Legal opcode cycle counts must leave at least one busy cycle (R2).
    always_comb begin
        if (dec_legal) assert (dec_cyc >= CNT_W'(2)) else $error("cycle count below 2");
    end

    // R2: an accepted start raises busy on the next cycle.
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && dec_legal) |=> busy_o);

    // R3: registers stay put whenever the unit is idle.
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(acc_a_o) && $stable(acc_b_o) && $stable(ccr_o)));

    // R3: a start while busy does not extend or restart the operation.
    p_busy_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy_o);

    // R6: logical operations clear V and keep C.
    p_and_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_q == OP_ANDA || op_q == OP_ANDB)) |=> (!ccr_q.v && $stable(ccr_q.c)));

    // R5: the double add keeps H.
    p_addd_keep_h_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_ADDD) |=> $stable(ccr_q.h));

    // R7: bit test writes neither accumulator.
    p_bit_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_q == OP_BITA) |=> ($stable(acc_a_o) && $stable(acc_b_o)));

    // R11: after any shift commits, V equals N XOR C.
    p_shift_v_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_q == OP_ASLA || op_q == OP_ASLB || op_q == OP_ASLD ||
                    op_q == OP_ASRA || op_q == OP_ASRB))
        |=> (ccr_q.v == (ccr_q.n ^ ccr_q.c)));

endmodule

// File: tb/acc_alu_core_tb.sv
// Self-checking bench: integer model of the accumulators and flags, swept
// over a grid of accumulator states for every opcode.
module acc_alu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opc = '0;
    logic [15:0] opnd = '0;
    logic        busy;
    logic [7:0]  acc_a, acc_b;
    logic [4:0]  ccr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int ma = 0, mb = 0, mh = 0, mn = 0, mz = 0, mv = 0, mc = 0;

    acc_alu_core u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opc),
        .operand_i(opnd), .busy_o(busy), .acc_a_o(acc_a), .acc_b_o(acc_b), .ccr_o(ccr)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sx(int x, int bits);
        return (x >= (1 << (bits - 1))) ? x - (1 << bits) : x;
    endfunction

    function automatic int cyc_of(logic [7:0] op);
        if (op == 8'hC3) return 4;
        if (op == 8'h05) return 3;
        return 2;
    endfunction

    function automatic string req_of(logic [7:0] op);
        case (op)
            8'hCB: return "R4 add B";
            8'hC3: return "R5 add D";
            8'h84, 8'hC4: return "R6 and";
            8'h85: return "R7 bit test";
            8'h48, 8'h58: return "R8/R11 shift left";
            8'h05: return "R9/R11 shift D";
            default: return "R10/R11 shift right";
        endcase
    endfunction

    function automatic int expected();
        return (ma << 13) | (mb << 5) | (mh << 4) | (mn << 3) | (mz << 2) | (mv << 1) | mc;
    endfunction

    // Reference model, built from R4..R12 with integer arithmetic.
    task automatic model(logic [7:0] op, int m);
        int lo = m % 256;
        int d  = ma * 256 + mb;
        int r, s;
        case (op)
            8'hCB: begin  // R4, R12
                r  = mb + lo;
                mh = ((mb % 16) + (lo % 16)) > 15;
                mc = r > 255;
                s  = sx(mb, 8) + sx(lo, 8);
                mv = (s > 127) || (s < -128);
                mb = r % 256;
                mn = mb >= 128; mz = mb == 0;
            end
            8'hC3: begin  // R5
                r  = d + m;
                mc = r > 65535;
                s  = sx(d, 16) + sx(m, 16);
                mv = (s > 32767) || (s < -32768);
                r  = r % 65536;
                ma = r / 256; mb = r % 256;
                mn = r >= 32768; mz = r == 0;
            end
            8'h84, 8'hC4, 8'h85: begin  // R6, R7
                r = (op == 8'hC4) ? (mb & lo) : (ma & lo);
                if (op == 8'h84) ma = r;
                if (op == 8'hC4) mb = r;
                mn = r >= 128; mz = r == 0; mv = 0;
            end
            8'h48, 8'h58: begin  // R8, R11
                s  = (op == 8'h48) ? ma : mb;
                mc = s >= 128;
                r  = (s * 2) % 256;
                if (op == 8'h48) ma = r; else mb = r;
                mn = r >= 128; mz = r == 0; mv = mn ^ mc;
            end
            8'h05: begin  // R9, R11
                mc = d >= 32768;
                r  = (d * 2) % 65536;
                ma = r / 256; mb = r % 256;
                mn = r >= 32768; mz = r == 0; mv = mn ^ mc;
            end
            default: begin  // R10, R11 (0x47, 0x57)
                s  = (op == 8'h47) ? ma : mb;
                mc = s % 2;
                r  = s / 2 + ((s >= 128) ? 128 : 0);
                if (op == 8'h47) ma = r; else mb = r;
                mn = r >= 128; mz = r == 0; mv = mn ^ mc;
            end
        endcase
    endtask

    // Issue one operation; optionally pulse a second start while busy.
    task automatic run_op(logic [7:0] op, int m, bit inject);
        int n = 0;
        int bad = 0;
        int pre;
        pre = int'({acc_a, acc_b, ccr});
        @(negedge clk);
        start = 1'b1; opc = op; opnd = m[15:0];
        @(negedge clk);
        start = inject; opc = 8'h48; opnd = 16'hFFFF;
        while (busy) begin
            n++;
            if (busy && n > 1 && int'({acc_a, acc_b, ccr}) != pre) bad = 1;
            @(negedge clk);
            start = 1'b0;
            if (n > 8) break;
        end
        chk("R2 busy length", n, cyc_of(op) - 1);
        chk("R2 hold while busy", bad, 0);
        model(op, m);
        chk(req_of(op), int'({acc_a, acc_b, ccr}), expected());
        if (inject) begin
            @(negedge clk);
            chk("R3 start while busy ignored", int'({busy, acc_a, acc_b, ccr}), expected());
        end
    endtask

    // Bring D to a target value through the double add.
    task automatic set_d(int target);
        int cur = ma * 256 + mb;
        run_op(8'hC3, (target - cur + 65536) % 65536, 1'b0);
    endtask

    function automatic int grid(int k);
        if (k < 16) return k * 17;
        if (k == 16) return 8'h7F;
        if (k == 17) return 8'h80;
        return 8'h01;
    endfunction

    localparam logic [7:0] OPS [10] = '{8'hCB, 8'hC3, 8'h84, 8'hC4, 8'h85,
                                        8'h48, 8'h58, 8'h05, 8'h47, 8'h57};

    initial begin
        int pre;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", int'({busy, acc_a, acc_b, ccr}), 0);

        // R4/R12 corners: half carry, signed overflow, wrap to zero.
        set_d(16'h007F); run_op(8'hCB, 16'h0001, 1'b0);
        set_d(16'h00FF); run_op(8'hCB, 16'h0001, 1'b0);
        set_d(16'h0080); run_op(8'hCB, 16'h0080, 1'b0);

        // R3: unknown opcode while idle.
        pre = int'({busy, acc_a, acc_b, ccr});
        @(negedge clk);
        start = 1'b1; opc = 8'hFF; opnd = 16'h1234;
        @(negedge clk);
        start = 1'b0;
        chk("R3 unknown opcode no busy", int'({busy, acc_a, acc_b, ccr}), pre);
        @(negedge clk);
        chk("R3 unknown opcode no change", int'({busy, acc_a, acc_b, ccr}), pre);

        // R3: start during a 4-cycle and a 2-cycle operation.
        run_op(8'hC3, 16'h4321, 1'b1);
        run_op(8'h84, 16'h00F0, 1'b1);

        // Sweep every opcode over a grid of accumulator states.
        for (int i = 0; i < 19; i++) begin
            for (int j = 0; j < 19; j++) begin
                for (int k = 0; k < 10; k++) begin
                    int x = grid(i);
                    int y = grid(j);
                    int m = (((x * 7 + y * 13 + k * 29) % 256) << 8) |
                            ((x * 3 + y * 11 + k * 41) % 256);
                    set_d(x * 256 + y);
                    run_op(OPS[k], m, 1'b0);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule